// File: doc/BRIEF.md
# Sleep Mode Entry and Exit Sequencer

This block controls the low-power sleep state of a synchronous memory. A sleep request arrives asynchronously and is active high. The block synchronizes it and then runs a fixed entry delay before the memory counts as asleep. While asleep, the block raises a gate that makes the memory ignore its synchronous inputs, and it forces the data outputs to high impedance. The memory then behaves as deselected. The block only gates; internal state and memory contents are not touched.

When the request drops, the block runs a wake-up delay of the same length before normal operation resumes. During the entry delay and during the wake-up delay, the block raises a restriction flag, because only deselect or read commands are safe in those cycles. If a write command arrives while the flag is high, the block sets a violation flag. That flag stays set until reset. If the request drops before the entry delay finishes, the block never sleeps. It runs the full wake-up delay instead and then returns to active.

The command type is a 2-bit code:
- 2'b00: deselect
- 2'b01: read
- 2'b10: write
- 2'b11: burst continue

Top module: `sleep_seq_ctrl`

## Requirements
- R1: After reset, all five outputs are low: `in_ignore`, `out_hiz`, `asleep`, `cmd_restrict` and `cmd_viol`.
- R2: The sleep request passes through a two-stage synchronizer. If the request is set up before rising edge 1, all outputs stay at their active values through edge 2. `cmd_restrict` rises at edge 3.
- R3: The entry window lasts exactly two cycles with `cmd_restrict` high. With a held request, `asleep` rises at edge 5 after the request, and `cmd_restrict` falls in the same cycle.
- R4: While asleep, `in_ignore` and `out_hiz` are high and `cmd_restrict` is low. The block stays in this state for as long as the request remains high.
- R5: When the request drops while asleep, `asleep`, `in_ignore` and `out_hiz` fall at edge 3 after the drop. `cmd_restrict` is high for exactly two cycles from that edge, then falls at edge 5.
- R6: A request pulse that is withdrawn before the entry window completes never raises `asleep`. For a one-cycle pulse, `cmd_restrict` is high after edges 3, 4 and 5 and low after edge 6: one entry cycle followed by the full two-cycle wake window.
- R7: A write (`cmd_kind` = 2'b10) sampled at a rising edge while `cmd_restrict` is high sets `cmd_viol` from that edge. `cmd_viol` stays high until reset.
- R8: The following never set `cmd_viol`:
  - deselect (2'b00), read (2'b01) or burst continue (2'b11) during a window;
  - writes while fully active;
  - writes while asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| cmd_kind | input | 2 | Command type: 00 deselect, 01 read, 10 write, 11 burst continue |
| in_ignore | output | 1 | Gate that blocks the memory's synchronous inputs while asleep |
| out_hiz | output | 1 | Forces the data outputs to high impedance |
| asleep | output | 1 | Sleep status |
| cmd_restrict | output | 1 | Entry or wake window: only deselect or read are allowed |
| cmd_viol | output | 1 | Sticky flag: a write was seen in a window |

## Verification
A wrong sequencer state shows directly on the ports:
- A miscounted entry or wake counter moves the edge where `asleep` or `cmd_restrict` changes by at least one cycle. The bench catches this by sampling the exact edge numbers from the request change.
- A lost abort path shows as `asleep` rising after a one-cycle pulse.
- A violation register that is not sticky drops `cmd_viol` within a cycle of the offending write.
- A violation register with a wrong enable sets `cmd_viol` within one cycle of a read, a continue, or a write outside the windows.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE   = 2'd0,
    ST_ENTERING = 2'd1,
    ST_ASLEEP   = 2'd2,
    ST_WAKING   = 2'd3
  } slp_state_t;

  localparam logic [1:0] CMD_DESEL = 2'b00;
  localparam logic [1:0] CMD_READ  = 2'b01;
  localparam logic [1:0] CMD_WRITE = 2'b10;
  localparam logic [1:0] CMD_CONT  = 2'b11;

  // counter width able to hold values 0..n-1
  function automatic int cnt_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  function automatic logic is_write(input logic [1:0] kind);
    return kind == CMD_WRITE;
  endfunction

  function automatic logic in_window(input slp_state_t s);
    return (s == ST_ENTERING) || (s == ST_WAKING);
  endfunction

endpackage

// File: rtl/sleep_req_sync.sv
module sleep_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_seq_pkg::*;
#(
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  output logic asleep,
  output logic window,
  output logic entry_done,
  output logic entry_abort,
  output logic wake_done
);
  localparam int MAXC  = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CNT_W = cnt_width(MAXC);
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);

  slp_state_t st;
  logic [CNT_W-1:0] cnt;
  logic cnt_zero;

  assign cnt_zero    = (cnt == '0);
  assign entry_abort = (st == ST_ENTERING) && !req_s;
  assign entry_done  = (st == ST_ENTERING) && req_s && cnt_zero;
  assign wake_done   = (st == ST_WAKING) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_ACTIVE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_ACTIVE: begin
          if (req_s) begin
            st  <= ST_ENTERING;
            cnt <= ENTRY_LOAD;
          end
        end
        ST_ENTERING: begin
          if (entry_abort) begin
            st  <= ST_WAKING;
            cnt <= EXIT_LOAD;
          end else if (entry_done) begin
            st <= ST_ASLEEP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ASLEEP: begin
          if (!req_s) begin
            st  <= ST_WAKING;
            cnt <= EXIT_LOAD;
          end
        end
        ST_WAKING: begin
          if (wake_done) st <= ST_ACTIVE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_ACTIVE;
      endcase
    end
  end

  assign asleep = (st == ST_ASLEEP);
  assign window = in_window(st);
endmodule

// File: rtl/sleep_cmd_guard.sv
module sleep_cmd_guard
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       window,
  input  logic [1:0] cmd_kind,
  output logic       viol
);
  logic bad_cmd;
  assign bad_cmd = window && is_write(cmd_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       viol <= 1'b0;
    else if (bad_cmd) viol <= 1'b1;
  end
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic [1:0] cmd_kind,
  output logic       in_ignore,
  output logic       out_hiz,
  output logic       asleep,
  output logic       cmd_restrict,
  output logic       cmd_viol
);
  logic req_s;
  logic slp;
  logic window;
  logic entry_done;
  logic entry_abort;
  logic wake_done;

  sleep_req_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sleep_req),
    .dout (req_s)
  );

  sleep_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s      (req_s),
    .asleep     (slp),
    .window     (window),
    .entry_done (entry_done),
    .entry_abort(entry_abort),
    .wake_done  (wake_done)
  );

  sleep_cmd_guard i_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .window  (window),
    .cmd_kind(cmd_kind),
    .viol    (cmd_viol)
  );

  assign asleep       = slp;
  assign in_ignore    = slp;
  assign out_hiz      = slp;
  assign cmd_restrict = window;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_kind,
  input logic       in_ignore,
  input logic       out_hiz,
  input logic       asleep,
  input logic       cmd_restrict,
  input logic       cmd_viol,
  input logic       entry_done,
  input logic       entry_abort,
  input logic       wake_done
);
  AST_ASLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (in_ignore && out_hiz && !cmd_restrict)); // R4
  AST_SLEEP_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(entry_done)); // R3
  AST_WAKE_FOLLOWS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> cmd_restrict); // R5
  AST_ACTIVE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> (!cmd_restrict && !asleep)); // R5
  AST_ABORT_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    entry_abort |=> (cmd_restrict && !asleep)); // R6
  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_restrict && cmd_kind == 2'b10) |=> cmd_viol); // R7
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_viol |=> cmd_viol); // R7
  AST_VIOL_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_viol) |-> $past(cmd_restrict && cmd_kind == 2'b10)); // R8
endmodule

bind sleep_seq_ctrl sleep_seq_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_kind    (cmd_kind),
  .in_ignore   (in_ignore),
  .out_hiz     (out_hiz),
  .asleep      (asleep),
  .cmd_restrict(cmd_restrict),
  .cmd_viol    (cmd_viol),
  .entry_done  (entry_done),
  .entry_abort (entry_abort),
  .wake_done   (wake_done)
);

// File: tb/test_sleep_seq_ctrl.sv
module test_sleep_seq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic in_ignore, out_hiz, asleep, cmd_restrict, cmd_viol;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sleep_seq_ctrl i_sleep_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cmd_kind(cmd_kind),
    .in_ignore(in_ignore), .out_hiz(out_hiz), .asleep(asleep),
    .cmd_restrict(cmd_restrict), .cmd_viol(cmd_viol)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // status packed as {in_ignore, out_hiz, asleep, cmd_restrict}
  task automatic chk_st(input string tag, input logic [3:0] exp);
    checks++;
    if ({in_ignore, out_hiz, asleep, cmd_restrict} !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag,
               {in_ignore, out_hiz, asleep, cmd_restrict}, exp);
    end
  endtask

  task automatic do_reset();
    sleep_req = 1'b0;
    cmd_kind  = 2'b00;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk_st("R1 status after reset", 4'b0000);
    chk("R1 viol after reset", cmd_viol, 1'b0);
  endtask

  task automatic t_entry_and_hold();
    sleep_req = 1'b1;
    step(2);
    chk_st("R2 still active after two edges", 4'b0000);
    step(1);
    chk_st("R2 entry window opens at edge 3", 4'b0001);
    step(1);
    chk_st("R3 entry window edge 4", 4'b0001);
    step(1);
    chk_st("R3 asleep at edge 5", 4'b1110);
    step(12);
    chk_st("R4 stays asleep while request high", 4'b1110);
  endtask

  task automatic t_wake();
    sleep_req = 1'b0;
    step(2);
    chk_st("R5 still asleep two edges after drop", 4'b1110);
    step(1);
    chk_st("R5 wake window opens at edge 3", 4'b0001);
    step(1);
    chk_st("R5 wake window edge 4", 4'b0001);
    step(1);
    chk_st("R5 active at edge 5", 4'b0000);
  endtask

  task automatic t_abort();
    do_reset();
    sleep_req = 1'b1;
    step(1);
    sleep_req = 1'b0;
    step(1);
    chk_st("R6 pulse edge 2", 4'b0000);
    step(1);
    chk_st("R6 pulse edge 3 window", 4'b0001);
    step(1);
    chk_st("R6 edge 4 aborted to wake", 4'b0001);
    step(1);
    chk_st("R6 edge 5 wake window", 4'b0001);
    step(1);
    chk_st("R6 edge 6 active, never asleep", 4'b0000);
  endtask

  task automatic t_allowed_cmds();
    do_reset();
    sleep_req = 1'b1;
    step(3);
    cmd_kind = 2'b01;
    step(1);
    cmd_kind = 2'b11;
    step(1);
    cmd_kind = 2'b00;
    chk("R4 asleep reached", asleep, 1'b1);
    sleep_req = 1'b0;
    step(3);
    cmd_kind = 2'b01;
    step(1);
    cmd_kind = 2'b11;
    step(1);
    cmd_kind = 2'b00;
    chk("R8 read/continue/deselect in windows no viol", cmd_viol, 1'b0);
  endtask

  task automatic t_write_outside();
    do_reset();
    cmd_kind = 2'b10;
    step(4);
    cmd_kind = 2'b00;
    chk("R8 write while active no viol", cmd_viol, 1'b0);
    sleep_req = 1'b1;
    step(5);
    chk("R4 asleep before sleep writes", asleep, 1'b1);
    cmd_kind = 2'b10;
    step(6);
    chk("R8 restrict low while asleep", cmd_restrict, 1'b0);
    cmd_kind = 2'b00;
    chk("R8 write while asleep no viol", cmd_viol, 1'b0);
    sleep_req = 1'b0;
    step(6);
    chk("R8 no viol after clean wake", cmd_viol, 1'b0);
  endtask

  task automatic t_write_viol();
    do_reset();
    sleep_req = 1'b1;
    step(5);
    sleep_req = 1'b0;
    step(3);
    chk("R7 in wake window", cmd_restrict, 1'b1);
    cmd_kind = 2'b10;
    step(1);
    cmd_kind = 2'b00;
    chk("R7 write in wake window sets viol", cmd_viol, 1'b1);
    step(20);
    chk("R7 viol sticky", cmd_viol, 1'b1);
    do_reset();
    chk("R7 viol cleared by reset", cmd_viol, 1'b0);
    sleep_req = 1'b1;
    step(4);
    cmd_kind = 2'b10;
    step(1);
    cmd_kind = 2'b00;
    chk("R7 write in entry window sets viol", cmd_viol, 1'b1);
    sleep_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_entry_and_hold();
    t_wake();
    t_abort();
    t_allowed_cmds();
    t_write_outside();
    t_write_viol();
    step(8);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule